// File: doc/BRIEF.md
# Read-While-Write Flash Access Controller

This block sits between a processor's program-memory read port and an on-chip program flash. The flash is divided into two fixed regions at a parameterised word address. Every address below `NRWW_BASE` belongs to the read-while-write (RWW) region. Every address at or above it belongs to the no-read-while-write (NRWW) region, which is where the boot loader lives. Page erase and page write commands arrive on a small command port. A simple cycle counter models the programming time.

The target region of a command decides how the processor is treated. When the target page is in the NRWW region, the processor is stalled for the whole operation. When the target page is in the RWW region, the processor keeps running but may only read from the NRWW region. Any read that lands in the RWW region returns an error flag and a fixed filler word. The RWW busy flag is sticky: it stays set after the operation completes and only drops when an explicit clear command arrives while the programmer is idle.

Top module: `rww_flash_ctrl`

## Requirements
- R1: A word address below `NRWW_BASE` is in the RWW region; an address at or above it is in the NRWW region. A command's region is taken from its page base address.
- R2: Command opcodes on `cmd_op_i` are 01 for erase, 10 for write, 11 for clear-busy and 00 for no operation. An erase sets every word of the addressed page to all ones. A write sets every word of the page to `cmd_data_i`. In both cases the array changes on the clock edge that ends the done cycle.
- R3: `done_o` is high for exactly one cycle. That cycle is the `ERASE_CYC`-th cycle (for an erase) or the `WRITE_CYC`-th cycle (for a write) after the edge that accepted the command.
- R4: `stall_o` is high from the cycle after an NRWW-target command is accepted through its done cycle. It is never high for an RWW-target command.
- R5: While `stall_o` is high, a read request gets no response: `rd_valid_o` is low in the following cycle.
- R6: Accepting an RWW-target command sets `busy_o` in the next cycle. The flag stays set after the operation completes, until a clear-busy command is accepted.
- R7: While `busy_o` is high, a read of an RWW address responds with `rd_err_o` high and data equal to `FILL_WORD`. Reads of NRWW addresses return array data with `rd_err_o` low.
- R8: An erase or write command presented while an operation is in progress, including during its done cycle, is ignored. It has no effect on the array contents, the timing or the flags.
- R9: A clear-busy command is honoured only when no operation is in progress; otherwise `busy_o` stays set.
- R10: After reset, `stall_o`, `done_o`, `busy_o`, `rd_valid_o` and `rd_err_o` are low, and every array word reads as all ones.
- R11: An accepted read responds one cycle after the request, with `rd_valid_o` high and the array word as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Opcode: 00 none, 01 erase, 10 write, 11 clear-busy |
| cmd_addr_i | input | ADDR_W | Word address inside the target page |
| cmd_data_i | input | DATA_W | Word programmed into every location of the page on write |
| rd_req_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_valid_o | output | 1 | Read response valid |
| rd_err_o | output | 1 | Read hit the blocked RWW region |
| rd_data_o | output | DATA_W | Read data, or `FILL_WORD` when blocked |
| stall_o | output | 1 | Processor halt during an NRWW operation |
| done_o | output | 1 | Single-cycle end-of-operation pulse |
| busy_o | output | 1 | Sticky RWW-blocked flag |

## Verification
The bench drives commands into the idle programmer, into running operations and into the done cycle. A design that accepts a command on the done cycle would restart its counter, and this shows up as a mistimed `done_o` or an unexpected page change. Clear commands are sent while an operation is running. A design that honours them early would drop `busy_o` and return real RWW data before the operation ends. Reads are aimed at the RWW region after completion but before the clear, which catches a busy flag that drops by itself on done. Reads during NRWW stalls catch a design that still answers while the processor is halted.

// File: rtl/rww_flash_pkg.sv
package rww_flash_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_ERASE = 2'b01,
    OP_WRITE = 2'b10,
    OP_CLEAR = 2'b11
  } rww_op_e;
endpackage

// File: rtl/rww_region_dec.sv
module rww_region_dec #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NRWW_BASE = 192
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_rww_o
);
  localparam logic [ADDR_W:0] BASE = (ADDR_W+1)'(NRWW_BASE);

  assign in_rww_o = ({1'b0, addr_i} < BASE);
endmodule

// File: rtl/rww_prog_seq.sv
module rww_prog_seq
  import rww_flash_pkg::*;
#(
  parameter int unsigned PG_W      = 5,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ERASE_CYC = 12,
  parameter int unsigned WRITE_CYC = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  rww_op_e           cmd_op_i,
  input  logic [PG_W-1:0]   cmd_page_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              cmd_in_rww_i,
  output logic              stall_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              commit_erase_o,
  output logic [PG_W-1:0]   commit_page_o,
  output logic [DATA_W-1:0] commit_data_o
);
  localparam int unsigned MAX_CYC = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] WRITE_LOAD = CNT_W'(WRITE_CYC - 1);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              nrww_q;
  logic              busy_q;
  rww_op_e           op_q;
  logic [PG_W-1:0]   page_q;
  logic [DATA_W-1:0] data_q;
  logic              start;

  assign start = cmd_valid_i && !active_q &&
                 (cmd_op_i == OP_ERASE || cmd_op_i == OP_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      nrww_q   <= 1'b0;
      busy_q   <= 1'b0;
      op_q     <= OP_NONE;
      page_q   <= '0;
      data_q   <= '0;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= (cmd_op_i == OP_ERASE) ? ERASE_LOAD : WRITE_LOAD;
      op_q     <= cmd_op_i;
      page_q   <= cmd_page_i;
      data_q   <= cmd_data_i;
      nrww_q   <= !cmd_in_rww_i;
      if (cmd_in_rww_i) busy_q <= 1'b1;
    end else if (cmd_valid_i && cmd_op_i == OP_CLEAR) begin
      busy_q <= 1'b0;
    end
  end

  assign done_o         = active_q && (cnt_q == '0);
  assign stall_o        = active_q && nrww_q;
  assign busy_o         = busy_q;
  assign commit_erase_o = (op_q == OP_ERASE);
  assign commit_page_o  = page_q;
  assign commit_data_o  = data_q;

  // R3
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  cmd_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !done_o) |=> ($stable(page_q) && $stable(op_q) && $stable(data_q)));
  // R9
  clear_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && active_q) |=> busy_o);
  // R4
  stall_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stall_o) |-> $past(done_o));
endmodule

// File: rtl/rww_flash_array.sv
module rww_flash_array #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PAGE_W    = 3,
  parameter int unsigned DATA_W    = 16,
  parameter logic [15:0] FILL_WORD = 16'hDEAD
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     commit_i,
  input  logic                     commit_erase_i,
  input  logic [ADDR_W-PAGE_W-1:0] commit_page_i,
  input  logic [DATA_W-1:0]        commit_data_i,
  input  logic                     rd_req_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  input  logic                     rd_in_rww_i,
  input  logic                     stall_i,
  input  logic                     busy_i,
  output logic                     rd_valid_o,
  output logic                     rd_err_o,
  output logic [DATA_W-1:0]        rd_data_o
);
  localparam int unsigned DEPTH      = 1 << ADDR_W;
  localparam int unsigned PAGE_WORDS = 1 << PAGE_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] pgm_word;

  assign pgm_word = commit_erase_i ? '1 : commit_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (commit_i) begin
      for (int w = 0; w < PAGE_WORDS; w++)
        mem_q[{commit_page_i, PAGE_W'(w)}] <= pgm_word;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_err_o   <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_req_i && !stall_i;
      rd_err_o   <= rd_req_i && !stall_i && rd_in_rww_i && busy_i;
      if (rd_req_i && !stall_i)
        rd_data_o <= (rd_in_rww_i && busy_i) ? DATA_W'(FILL_WORD) : mem_q[rd_addr_i];
    end
  end

  // R5
  stall_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && stall_i) |=> !rd_valid_o);
  // R7
  err_has_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> (rd_valid_o && rd_data_o == DATA_W'(FILL_WORD)));
  // R11
  read_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_req_i));
endmodule

// File: rtl/rww_flash_ctrl.sv
module rww_flash_ctrl
  import rww_flash_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PAGE_W    = 3,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned NRWW_BASE = 192,
  parameter int unsigned ERASE_CYC = 12,
  parameter int unsigned WRITE_CYC = 6,
  parameter logic [15:0] FILL_WORD = 16'hDEAD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_valid_o,
  output logic              rd_err_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              stall_o,
  output logic              done_o,
  output logic              busy_o
);
  localparam int unsigned PG_W = ADDR_W - PAGE_W;

  logic [PG_W-1:0]   cmd_page;
  logic [ADDR_W-1:0] cmd_base;
  logic              cmd_in_rww;
  logic              rd_in_rww;
  logic              commit_erase;
  logic [PG_W-1:0]   commit_page;
  logic [DATA_W-1:0] commit_data;

  assign cmd_page = cmd_addr_i[ADDR_W-1:PAGE_W];
  assign cmd_base = {cmd_page, {PAGE_W{1'b0}}};

  rww_region_dec #(.ADDR_W(ADDR_W), .NRWW_BASE(NRWW_BASE)) u_dec_cmd (
    .addr_i(cmd_base), .in_rww_o(cmd_in_rww));

  rww_region_dec #(.ADDR_W(ADDR_W), .NRWW_BASE(NRWW_BASE)) u_dec_rd (
    .addr_i(rd_addr_i), .in_rww_o(rd_in_rww));

  rww_prog_seq #(
    .PG_W(PG_W), .DATA_W(DATA_W), .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .cmd_valid_i,
    .cmd_op_i      (rww_op_e'(cmd_op_i)),
    .cmd_page_i    (cmd_page),
    .cmd_data_i,
    .cmd_in_rww_i  (cmd_in_rww),
    .stall_o, .done_o, .busy_o,
    .commit_erase_o(commit_erase),
    .commit_page_o (commit_page),
    .commit_data_o (commit_data)
  );

  rww_flash_array #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .FILL_WORD(FILL_WORD)
  ) u_array (
    .clk_i, .rst_ni,
    .commit_i      (done_o),
    .commit_erase_i(commit_erase),
    .commit_page_i (commit_page),
    .commit_data_i (commit_data),
    .rd_req_i, .rd_addr_i,
    .rd_in_rww_i   (rd_in_rww),
    .stall_i       (stall_o),
    .busy_i        (busy_o),
    .rd_valid_o, .rd_err_o, .rd_data_o
  );

  // R6
  busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !stall_o && !done_o && !busy_o && cmd_in_rww &&
     (cmd_op_i == 2'b01 || cmd_op_i == 2'b10)) |=> busy_o);
  // R4
  stall_not_rww_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(!cmd_in_rww));
  // R1
  nrww_read_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !rd_in_rww && !stall_o) |=> (rd_valid_o && !rd_err_o));
endmodule

// File: tb/rww_flash_ctrl_bench.sv
module rww_flash_ctrl_bench;
  localparam int ADDR_W = 8, PAGE_W = 3, DATA_W = 16;
  localparam int NRWW_BASE = 192, ERASE_CYC = 12, WRITE_CYC = 6;
  localparam logic [15:0] FILL = 16'hDEAD;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk_i = 0, rst_ni = 0;
  logic cmd_valid_i = 0;
  logic [1:0] cmd_op_i = 0;
  logic [ADDR_W-1:0] cmd_addr_i = 0;
  logic [DATA_W-1:0] cmd_data_i = 0;
  logic rd_req_i = 0;
  logic [ADDR_W-1:0] rd_addr_i = 0;
  logic rd_valid_o, rd_err_o, stall_o, done_o, busy_o;
  logic [DATA_W-1:0] rd_data_o;

  always #5 clk_i = ~clk_i;

  rww_flash_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
    .NRWW_BASE(NRWW_BASE), .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC),
    .FILL_WORD(FILL)) u_rww_flash_ctrl (.*);

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference state
  logic [DATA_W-1:0] m_mem [DEPTH];
  bit m_active, m_nrww, m_busy, m_erase;
  int m_cnt;
  logic [ADDR_W-PAGE_W-1:0] m_page;
  logic [DATA_W-1:0] m_data;
  bit e_valid, e_err;
  logic [DATA_W-1:0] e_data;

  function automatic bit in_rww(logic [ADDR_W-1:0] a);
    return int'(a) < NRWW_BASE;
  endfunction

  function automatic int op_len(logic [1:0] op);
    return (op == 2'b01) ? ERASE_CYC : WRITE_CYC;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '1;
    m_active = 0; m_nrww = 0; m_busy = 0; m_cnt = 0; e_valid = 0; e_err = 0; e_data = 0;
  endtask

  // one clock edge of the reference, using inputs held since the last negedge
  task automatic model_step();
    bit stalled = m_active && m_nrww;
    if (rd_req_i && !stalled) begin
      e_valid = 1;
      e_err = in_rww(rd_addr_i) && m_busy;
      e_data = e_err ? FILL : m_mem[rd_addr_i];
    end else begin
      e_valid = 0; e_err = 0;
    end
    if (m_active) begin
      if (m_cnt == 0) begin
        for (int w = 0; w < (1 << PAGE_W); w++)
          m_mem[{m_page, PAGE_W'(w)}] = m_erase ? '1 : m_data;
        m_active = 0;
      end else m_cnt--;
    end else if (cmd_valid_i && (cmd_op_i == 2'b01 || cmd_op_i == 2'b10)) begin
      m_active = 1; m_cnt = op_len(cmd_op_i) - 1; m_erase = (cmd_op_i == 2'b01);
      m_page = cmd_addr_i[ADDR_W-1:PAGE_W]; m_data = cmd_data_i;
      m_nrww = !in_rww({m_page, {PAGE_W{1'b0}}});
      if (!m_nrww) m_busy = 1;
    end else if (cmd_valid_i && cmd_op_i == 2'b11) m_busy = 0;
  endtask

  task automatic compare();
    chk("R4 stall", stall_o, m_active && m_nrww);
    chk("R3 done", done_o, m_active && m_cnt == 0);
    chk("R6/R9 busy", busy_o, m_busy);
    chk("R5/R11 rd_valid", rd_valid_o, e_valid);
    chk("R1/R7 rd_err", rd_err_o, e_err);
    if (e_valid) chk("R2/R7 rd_data", rd_data_o, e_data);
  endtask

  task automatic cycle();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare();
    cmd_valid_i = 0; rd_req_i = 0;
  endtask

  task automatic cmd(logic [1:0] op, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    cmd_valid_i = 1; cmd_op_i = op; cmd_addr_i = a; cmd_data_i = d;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a);
    rd_req_i = 1; rd_addr_i = a;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    #12;
    // R10 reset state
    chk("R10 stall", stall_o, 0); chk("R10 done", done_o, 0);
    chk("R10 busy", busy_o, 0); chk("R10 rd_valid", rd_valid_o, 0);
    chk("R10 rd_err", rd_err_o, 0);
    @(negedge clk_i); rst_ni = 1;
    rd(8'h05); cycle();           // R10 erased word reads all ones
    chk("R10 erased", rd_data_o, 16'hFFFF);

    // R2/R8: NRWW write, stall, commands during operation ignored
    cmd(2'b10, 8'hC9, 16'h1234); cycle();
    rd(8'hC8); cmd(2'b01, 8'h10, 0); cycle();         // R5 no response, R8 ignored
    for (int i = 0; i < WRITE_CYC - 2; i++) begin cmd(2'b11, 0, 0); cycle(); end
    cmd(2'b01, 8'hC8, 0); cycle();                     // R8 done cycle command ignored
    rd(8'hCF); cycle(); cycle();
    chk("R2 write word", rd_data_o, 16'h1234);

    // R6/R7/R9: RWW write, NRWW read ok, RWW read blocked, early clear ignored
    cmd(2'b10, 8'h22, 16'hA5A5); cycle();
    rd(8'hC0); cycle();
    rd(8'h20); cmd(2'b11, 0, 0); cycle();
    for (int i = 0; i < WRITE_CYC + 2; i++) begin rd(8'h21); cycle(); end
    chk("R6 sticky busy", busy_o, 1);
    cmd(2'b11, 0, 0); cycle();
    rd(8'h27); cycle(); cycle();
    chk("R2 rww write", rd_data_o, 16'hA5A5);

    // R2 erase RWW page back, boundary pages
    cmd(2'b01, 8'h20, 0); repeat (ERASE_CYC + 1) cycle();
    cmd(2'b11, 0, 0); cycle();
    rd(8'h23); cycle(); cycle();
    chk("R2 erase", rd_data_o, 16'hFFFF);
    cmd(2'b10, 8'(NRWW_BASE - 1), 16'h0F0F); repeat (WRITE_CYC + 1) cycle();   // R1 last RWW page
    cmd(2'b10, 8'(NRWW_BASE), 16'hF0F0); repeat (WRITE_CYC + 1) cycle();       // R1 first NRWW page

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 12) cmd(2'($urandom_range(1, 2)), 8'($urandom), 16'($urandom));
      else if (r < 22) cmd(2'b11, 0, 0);
      if ($urandom_range(0, 99) < 70) rd(8'($urandom));
      cycle();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule